// File: doc/BRIEF.md
# Host Data Polling Controller

This block sits on the host side of a parallel flash interface and decides whether a program or erase that the host has already launched has passed or failed. It polls one valid address over a request/acknowledge read port. Each returned byte is judged on two status bits: the polling bit (bit 7) and the timeout bit (bit 5). The polling bit is compared against the value the device shows once the operation has finished. For a program, that value is bit 7 of the programmed byte. For an erase, it is 1.

While the polling bit disagrees and the timeout bit is clear, the block keeps polling. If the timeout bit is set, the two status bits may have changed together, so the block makes one more read and judges the polling bit again. Only then does it declare failure. The polling bit can settle before the rest of the byte. For that reason, every pass is followed by one fresh read, and that byte is presented as the verified data.

A run ends with a single-cycle `done_o` pulse carrying either `pass_o` or `fail_o`.

Top module: `data_poll_ctrl`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `pass_o` and `fail_o` are low and `data_o` is zero.
- R2: A `start_i` pulse while idle captures `addr_i`, `exp_data_i` and `erase_i`. From the next cycle `rd_req_o` is high with `rd_addr_o` equal to the captured address. The address holds for the whole run, and each `rd_ack_i` completes one read whose byte is on `rd_data_i`.
- R3: The polling bit is bit 7 of the read byte. It matches when it equals bit 7 of the captured expected byte while `erase_i` was 0, or when it equals 1 while `erase_i` was 1.
- R4: A poll whose bit 7 mismatches and whose bit 5 is 0 is followed by another poll read.
- R5: A poll whose bit 7 mismatches and whose bit 5 is 1 is followed by exactly one re-read. If bit 7 of the re-read matches, the run continues as a pass.
- R6: If bit 7 of that re-read also mismatches, the run ends as a fail with no further read.
- R7: Once bit 7 matches, exactly one further read is made. Its whole byte appears on `data_o` when `done_o` pulses with `pass_o`.
- R8: `done_o` is high for one cycle, in the cycle after the final acknowledge. `pass_o` and `fail_o` are only high with `done_o` and never together.
- R9: `start_i` has no effect while a run is in progress: the address, the expected value and the result of the current run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a polling run (idle only) |
| erase_i | input | 1 | 1: erase run (expected bit 7 is 1); 0: program run |
| addr_i | input | AW | Valid address to poll |
| exp_data_i | input | DW | Programmed byte (bit 7 used) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` valid |
| rd_data_i | input | DW | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Run passed (with `done_o`) |
| fail_o | output | 1 | Run failed (with `done_o`) |
| data_o | output | DW | Verified byte from the final read after a pass |

## Verification
The hardest case to reach is the timeout bit set in the same poll that still shows the wrong polling bit. That case must then be followed by a re-read that either settles or stays wrong. The bench's device model returns a scripted byte sequence per run. A sweep covers both run kinds, both expected bit values, and every first-poll pattern: immediate match, plain miss, timeout with late match, and timeout with persistent miss. Acknowledge latency also varies, so each pattern arrives at different spacings.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_POLL    = 2'd1,
    ST_RECHECK = 2'd2,
    ST_VERIFY  = 2'd3
  } dpc_state_e;
endpackage

// File: rtl/dpc_judge.sv
module dpc_judge (
  input  logic erase_i,
  input  logic exp_bit_i,
  input  logic poll_bit_i,
  input  logic tmo_bit_i,
  output logic match_o,
  output logic tmo_o
);
  logic want;
  assign want    = erase_i ? 1'b1 : exp_bit_i;
  assign match_o = (poll_bit_i == want);
  assign tmo_o   = tmo_bit_i;
endmodule

// File: rtl/dpc_fsm.sv
module dpc_fsm
  import dpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       ack_i,
  input  logic       match_i,
  input  logic       tmo_i,
  output dpc_state_e state_o,
  output logic       accept_o,
  output logic       req_o,
  output logic       fin_pass_o,
  output logic       fin_fail_o
);
  dpc_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    fin_pass_o = 1'b0;
    fin_fail_o = 1'b0;
    accept_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        accept_o = 1'b1;
        state_d  = ST_POLL;
      end
      ST_POLL: if (ack_i) begin
        if (match_i)    state_d = ST_VERIFY;
        else if (tmo_i) state_d = ST_RECHECK;
      end
      ST_RECHECK: if (ack_i) begin
        if (match_i) state_d = ST_VERIFY;
        else begin
          state_d    = ST_IDLE;
          fin_fail_o = 1'b1;
        end
      end
      ST_VERIFY: if (ack_i) begin
        state_d    = ST_IDLE;
        fin_pass_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;
  assign req_o   = (state_q != ST_IDLE);

  // R6
  fail_from_recheck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_fail_o |-> (state_q == ST_RECHECK) && !match_i);
  // R4
  poll_again_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL && ack_i && !match_i && !tmo_i) |=> state_q == ST_POLL);
endmodule

// File: rtl/dpc_result.sv
module dpc_result #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fin_pass_i,
  input  logic          fin_fail_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      data_o <= '0;
    end else begin
      done_o <= fin_pass_i | fin_fail_i;
      pass_o <= fin_pass_i;
      fail_o <= fin_fail_i;
      if (fin_pass_i) data_o <= rd_data_i;
    end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o | fail_o) |-> done_o && !(pass_o && fail_o));
endmodule

// File: rtl/data_poll_ctrl.sv
module data_poll_ctrl
  import dpc_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TMO_BIT  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [DW-1:0] data_o
);
  dpc_state_e state;
  logic accept, match, tmo, fin_pass, fin_fail;
  logic [AW-1:0] addr_q;
  logic exp_q, erase_q;
  logic unused_exp;

  // only the polling bit of the programmed byte is compared
  assign unused_exp = ^exp_data_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q  <= '0;
      exp_q   <= 1'b0;
      erase_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      exp_q   <= exp_data_i[POLL_BIT];
      erase_q <= erase_i;
    end

  dpc_judge u_judge (
    .erase_i   (erase_q),
    .exp_bit_i (exp_q),
    .poll_bit_i(rd_data_i[POLL_BIT]),
    .tmo_bit_i (rd_data_i[TMO_BIT]),
    .match_o   (match),
    .tmo_o     (tmo)
  );

  dpc_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ack_i     (rd_ack_i),
    .match_i   (match),
    .tmo_i     (tmo),
    .state_o   (state),
    .accept_o  (accept),
    .req_o     (rd_req_o),
    .fin_pass_o(fin_pass),
    .fin_fail_o(fin_fail)
  );

  dpc_result #(.DW(DW)) u_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fin_pass_i(fin_pass),
    .fin_fail_i(fin_fail),
    .rd_data_i (rd_data_i),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .data_o    (data_o)
  );

  assign rd_addr_o = addr_q;

  // R2 R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o));
  // R5
  recheck_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RECHECK && rd_ack_i) |=> state != ST_RECHECK);
  // R7
  pass_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> $past(rd_ack_i) && $past(state == ST_VERIFY));
endmodule

// File: tb/sim_data_poll_ctrl.sv
module sim_data_poll_ctrl;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic start = 0, erase = 0, ack = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] exp_d = '0, rd_data = '0;
  logic rd_req, done, pass, fail;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] data;

  int checks = 0, fails = 0, cycles = 0;
  logic [DW-1:0] scr [0:7];
  int idx = 0, lat = 1, cnt = 0, reads = 0, dones = 0;
  logic addr_bad = 0;
  logic [AW-1:0] run_addr = '0;

  always #4 clk = ~clk;

  data_poll_ctrl #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .erase_i(erase),
    .addr_i(addr), .exp_data_i(exp_d), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_ack_i(ack), .rd_data_i(rd_data), .done_o(done), .pass_o(pass),
    .fail_o(fail), .data_o(data));

  // device model: acknowledge after lat request cycles
  always @(negedge clk) begin
    cycles++;
    ack <= 0;
    if (done) dones++;
    if (rd_req && rd_addr != run_addr) addr_bad <= 1;
    if (rd_req && !ack) begin
      cnt++;
      if (cnt >= lat) begin
        ack <= 1;
        rd_data <= scr[idx];
        idx++;
        reads++;
        cnt = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // run one scripted poll; pat: 0 match, 1 miss then match, 2 tmo then match, 3 tmo then miss
  task automatic run(input logic er, input logic eb, input int pat, input int l,
                     input logic poke);
    logic e, nb;
    logic [DW-1:0] vbyte;
    int n, wait_c;
    logic exp_pass;
    e = er ? 1'b1 : eb;
    nb = ~e;
    vbyte = {e, 7'(8'h35 ^ pat[6:0] ^ {l[5:0], 1'b0})};
    case (pat)
      0: begin scr[0] = {e, 7'h04}; scr[1] = vbyte; n = 2; exp_pass = 1; end
      1: begin scr[0] = {nb, 7'h01}; scr[1] = {nb, 7'h1A}; scr[2] = {e, 7'h00};
               scr[3] = vbyte; n = 4; exp_pass = 1; end
      2: begin scr[0] = {nb, 7'h20}; scr[1] = {e, 7'h20}; scr[2] = vbyte;
               n = 3; exp_pass = 1; end
      default: begin scr[0] = {nb, 7'h22}; scr[1] = {nb, 7'h20}; n = 2; exp_pass = 0; end
    endcase
    @(negedge clk);
    idx = 0; reads = 0; dones = 0; lat = l; cnt = 0; addr_bad = 0;
    run_addr = 16'h1000 + 16'(pat * 16 + l);
    addr = run_addr; erase = er; exp_d = {eb, 7'h5A};
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 req", int'(rd_req), 1);
    chk("R2 addr", int'(rd_addr), int'(run_addr));
    if (poke) begin
      addr = 16'hBEEF; erase = ~er; exp_d = ~exp_d; start = 1;
      @(negedge clk);
      start = 0;
    end
    wait_c = 0;
    while (!done && wait_c < 200) begin @(negedge clk); wait_c++; end
    chk("R8 done", int'(done), 1);
    chk(exp_pass ? "R7 pass" : "R6 fail", int'(pass), int'(exp_pass));
    chk("R8 fail", int'(fail), int'(!exp_pass));
    chk(pat == 1 ? "R4 reads" : pat == 3 ? "R6 reads" : "R5 reads", reads, n);
    if (exp_pass) chk("R7 data", int'(data), int'(vbyte));
    chk("R3 R9 addr", int'(addr_bad), 0);
    @(negedge clk);
    chk("R8 pulse", int'(done), 0);
    repeat (3) @(negedge clk);
    chk("R6 R7 no extra read", reads, n);
    chk("R8 one done", dones, 1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) scr[i] = '0;
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        finish_up();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 req", int'(rd_req), 0);
    chk("R1 done", int'(done | pass | fail), 0);
    chk("R1 data", int'(data), 0);
    rst_n = 1;
    @(negedge clk);
    for (int er = 0; er < 2; er++)
      for (int eb = 0; eb < 2; eb++)
        for (int pat = 0; pat < 4; pat++)
          for (int l = 1; l < 4; l++)
            run(er[0], eb[0], pat, l, 1'b0);
    // R9: start during a run is ignored
    run(1'b0, 1'b1, 1, 2, 1'b1);
    run(1'b1, 1'b0, 3, 3, 1'b1);
    run(1'b0, 1'b0, 2, 1, 1'b1);
    finish_up();
  end
endmodule